// File: doc/BRIEF.md
# Link Power Status Monitor

This block decides, from one status line driven by the link-layer controller, whether that controller is powered. The line may be held steadily high or toggled as a pulse train. A low stretch that lasts longer than a first threshold moves the interface into a quiet reset state. A low stretch that lasts longer than a second, larger threshold moves it into a disabled state.

The block holds the physical-to-link interface outputs according to that state. In reset, it zeroes the control and data outputs and masks the request line, but the interface clock keeps running. In disabled, the interface clock is also stopped. The clock gate only changes while the clock is low, so the gated clock never carries a runt pulse.

A separate link-active flag is produced for the status packet. It is set only while the line is judged active and software has set the link-control bit. A power-down input forces the interface into reset. Both thresholds and the minimum valid high time are parameters counted in system clock cycles.

Top module: `linkpwr_monitor`

## Requirements
- R1: After reset, `pwrState` reads 0 (active), and control, data and request pass unchanged from input to output.
- R2: The status input passes through a two-flop synchronizer. If it then stays low continuously, `pwrState` changes from 0 to 1 (reset) exactly on the (RESET_CYCLES+3)th rising edge, counting the first edge that samples the low level as edge 1.
- R3: If the low level continues, `pwrState` changes from 1 to 2 (disabled) exactly on the (DISABLE_CYCLES+3)th such edge. The low-time count saturates, so the state stays at 2 for as long as the input stays low, and state 2 is never entered straight from 0.
- R4: A pulse train whose high parts last at least MIN_HIGH cycles keeps `pwrState` at 0 when every low part, plus MIN_HIGH-1, is shorter than RESET_CYCLES.
- R5: A high pulse lasting fewer than MIN_HIGH cycles does not restart the low-time count: the state transitions keep the timing of R2 and R3, counted from the start of the low stretch.
- R6: While `pwrState` is 1 or 2, `ctlOut` and `dataOut` are all zero and `reqOut` is 0, whatever `ctlIn`, `dataIn` and `reqIn` are.
- R7: In state 1 the interface clock output keeps toggling. From the first high phase after the state becomes 2, `ifClkOut` is held low. It toggles again from the first high phase after the state leaves 2.
- R8: From state 1 or 2, if the input goes high and stays high, `pwrState` returns to 0 on the (MIN_HIGH+2)th rising edge after the input goes high.
- R9: `linkActive` is 1 exactly when `pwrState` is 0 and `linkCtrlBit` is 1.
- R10: While `powerDown` is 1, `pwrState` is 1 from the next rising edge on, unless the low-time rule calls for 2. Once `powerDown` returns to 0 with the input valid high, the state is 0 on the next edge.
- R11: The clock gate enable is updated only on the falling clock edge, so `ifClkOut` never goes high in the middle of a clock high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| statusIn | input | 1 | Raw link power status line (level or pulse train) |
| powerDown | input | 1 | Forces the interface into the reset state when high |
| linkCtrlBit | input | 1 | Software link-control bit |
| reqIn | input | 1 | Request line from the link controller |
| ctlIn | input | CTL_W | Control value to drive toward the link |
| dataIn | input | DATA_W | Data value to drive toward the link |
| reqOut | output | 1 | Request line after masking |
| ctlOut | output | CTL_W | Control output, zero unless active |
| dataOut | output | DATA_W | Data output, zero unless active |
| ifClkOut | output | 1 | Gated interface clock |
| linkActive | output | 1 | Link-active flag for the status packet |
| pwrState | output | 2 | 0 active, 1 reset, 2 disabled |

## Verification
The bench sweeps a long low stretch cycle by cycle and checks the state on every edge against the threshold arithmetic. A counter that is off by one, or that ignores the synchronizer delay, therefore shows up as an early or late transition. Short high glitches are inserted into a low stretch: a filter that let them clear the count would delay the reset transition. Pulse trains with low parts just under the limit are also applied, and would falsely drop a design that counts across high pulses. Recovery timing from both low states, clock stopping and restarting, output blanking with changing data patterns, the link-active flag under both control-bit values, and power-down entry and release are each checked at exact edges.

// File: rtl/linkpwr_pkg.sv
package linkpwr_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE   = 2'd0,
    PS_RESET    = 2'd1,
    PS_DISABLED = 2'd2
  } pwrState_e;

  typedef struct packed {
    logic passThru;   // forward control, data and request
    logic clkEnable;  // let the interface clock run
    logic linkUp;     // line judged active
  } ctrlStrobes_t;

endpackage

// File: rtl/linkpwr_filter.sv
module linkpwr_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic statusIn,
  output logic validHigh
);
  localparam int HC_W = $clog2(MIN_HIGH + 1);
  localparam logic [HC_W-1:0] HC_MAX  = HC_W'(MIN_HIGH);
  localparam logic [HC_W-1:0] HC_GATE = HC_W'(MIN_HIGH - 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [HC_W-1:0]        hiCnt;
  logic                   syncHi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncReg <= '0;
    else        syncReg <= {syncReg[SYNC_STAGES-2:0], statusIn};
  end

  assign syncHi = syncReg[SYNC_STAGES-1];

  // count consecutive synchronized high cycles, saturating at MIN_HIGH
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hiCnt <= '0;
    else if (!syncHi)      hiCnt <= '0;
    else if (hiCnt != HC_MAX) hiCnt <= hiCnt + 1'b1;
  end

  assign validHigh = syncHi && (hiCnt >= HC_GATE);

endmodule

// File: rtl/linkpwr_ctrl.sv
module linkpwr_ctrl
  import linkpwr_pkg::*;
#(
  parameter int RESET_CYCLES   = 650000,
  parameter int DISABLE_CYCLES = 6500000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         validHigh,
  input  logic         powerDown,
  output pwrState_e    stateQ,
  output ctrlStrobes_t strobes
);
  localparam int LOW_W = $clog2(DISABLE_CYCLES + 1);
  localparam logic [LOW_W-1:0] RST_LIM = LOW_W'(RESET_CYCLES);
  localparam logic [LOW_W-1:0] DIS_LIM = LOW_W'(DISABLE_CYCLES);

  logic [LOW_W-1:0] lowCnt;
  pwrState_e        stateNext;

  // low-time counter: cleared only by a validated high, saturates at disable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lowCnt <= '0;
    else if (validHigh)       lowCnt <= '0;
    else if (lowCnt != DIS_LIM) lowCnt <= lowCnt + 1'b1;
  end

  always_comb begin
    if (validHigh && !powerDown)        stateNext = PS_ACTIVE;
    else if (lowCnt == DIS_LIM)         stateNext = PS_DISABLED;
    else if (powerDown || lowCnt >= RST_LIM) stateNext = PS_RESET;
    else                                stateNext = PS_ACTIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= PS_ACTIVE;
    else        stateQ <= stateNext;
  end

  always_comb begin
    strobes.passThru  = (stateQ == PS_ACTIVE);
    strobes.clkEnable = (stateQ != PS_DISABLED);
    strobes.linkUp    = (stateQ == PS_ACTIVE);
  end

endmodule

// File: rtl/linkpwr_datapath.sv
module linkpwr_datapath
  import linkpwr_pkg::*;
#(
  parameter int CTL_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic              linkCtrlBit,
  input  logic              reqIn,
  input  logic [CTL_W-1:0]  ctlIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              reqOut,
  output logic [CTL_W-1:0]  ctlOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              ifClkOut,
  output logic              linkActive
);
  logic clkEnLow;

  assign ctlOut     = strobes.passThru ? ctlIn  : '0;
  assign dataOut    = strobes.passThru ? dataIn : '0;
  assign reqOut     = strobes.passThru & reqIn;
  assign linkActive = strobes.linkUp & linkCtrlBit;

  // enable captured while clk is low, so the AND never slices a high phase
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) clkEnLow <= 1'b1;
    else        clkEnLow <= strobes.clkEnable;
  end

  assign ifClkOut = clk & clkEnLow;

endmodule

// File: rtl/linkpwr_monitor.sv
module linkpwr_monitor
  import linkpwr_pkg::*;
#(
  parameter int RESET_CYCLES   = 650000,
  parameter int DISABLE_CYCLES = 6500000,
  parameter int MIN_HIGH       = 6,
  parameter int CTL_W          = 2,
  parameter int DATA_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              statusIn,
  input  logic              powerDown,
  input  logic              linkCtrlBit,
  input  logic              reqIn,
  input  logic [CTL_W-1:0]  ctlIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              reqOut,
  output logic [CTL_W-1:0]  ctlOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              ifClkOut,
  output logic              linkActive,
  output logic [1:0]        pwrState
);
  logic         validHigh;
  pwrState_e    stateQ;
  ctrlStrobes_t strobes;

  linkpwr_filter #(.SYNC_STAGES(2), .MIN_HIGH(MIN_HIGH)) u_filter (
    .clk(clk), .rst_n(rst_n), .statusIn(statusIn), .validHigh(validHigh)
  );

  linkpwr_ctrl #(.RESET_CYCLES(RESET_CYCLES), .DISABLE_CYCLES(DISABLE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .validHigh(validHigh), .powerDown(powerDown),
    .stateQ(stateQ), .strobes(strobes)
  );

  linkpwr_datapath #(.CTL_W(CTL_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .linkCtrlBit(linkCtrlBit),
    .reqIn(reqIn), .ctlIn(ctlIn), .dataIn(dataIn), .reqOut(reqOut),
    .ctlOut(ctlOut), .dataOut(dataOut), .ifClkOut(ifClkOut), .linkActive(linkActive)
  );

  assign pwrState = stateQ;

endmodule

// File: rtl/linkpwr_monitor_chk.sv
module linkpwr_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       powerDown,
  input logic       linkCtrlBit,
  input logic       anyOut,
  input logic       linkActive,
  input logic [1:0] pwrState
);
  p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrState != 2'd0) |-> !anyOut);

  p_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    linkActive |-> (pwrState == 2'd0 && linkCtrlBit));

  p_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    powerDown |=> (pwrState != 2'd0));

  p_no_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrState == 2'd0) |=> (pwrState != 2'd2));

  p_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pwrState != 2'd3);

endmodule

bind linkpwr_monitor linkpwr_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .powerDown(powerDown), .linkCtrlBit(linkCtrlBit),
  .anyOut(|{ctlOut, dataOut, reqOut}), .linkActive(linkActive), .pwrState(pwrState)
);

// File: tb/sim_linkpwr_monitor.sv
`timescale 1ns/1ps
module sim_linkpwr_monitor;
  localparam int RST_T = 20;
  localparam int DIS_T = 50;
  localparam int MINH  = 3;

  logic clk = 0, rst_n = 0, statusIn = 1, powerDown = 0, linkCtrlBit = 1, reqIn = 0;
  logic [1:0] ctlIn = 0;
  logic [7:0] dataIn = 0;
  logic reqOut, ifClkOut, linkActive;
  logic [1:0] ctlOut, pwrState;
  logic [7:0] dataOut;
  int checks = 0, errors = 0;
  int prevExp = 0;
  bit done = 0;

  always #2 clk = ~clk;

  linkpwr_monitor #(.RESET_CYCLES(RST_T), .DISABLE_CYCLES(DIS_T), .MIN_HIGH(MINH),
    .CTL_W(2), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .statusIn(statusIn), .powerDown(powerDown),
    .linkCtrlBit(linkCtrlBit), .reqIn(reqIn), .ctlIn(ctlIn), .dataIn(dataIn),
    .reqOut(reqOut), .ctlOut(ctlOut), .dataOut(dataOut), .ifClkOut(ifClkOut),
    .linkActive(linkActive), .pwrState(pwrState));

  task automatic checkEq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock: sample after the rising edge, then return on the falling edge
  task automatic tick(int exp, string tag);
    @(posedge clk); #1;
    checkEq(tag, "state", pwrState, exp);
    checkEq("R6", "ctl",  ctlOut,  exp == 0 ? ctlIn  : 0);
    checkEq("R6", "data", dataOut, exp == 0 ? dataIn : 0);
    checkEq("R6", "req",  reqOut,  exp == 0 ? reqIn  : 0);
    checkEq("R9", "linkActive", linkActive, (exp == 0 && linkCtrlBit) ? 1 : 0);
    checkEq("R7", "clock high phase", ifClkOut, prevExp != 2 ? 1 : 0);
    prevExp = exp;
    @(negedge clk);
    dataIn = dataIn * 8'd5 + 8'd29;
    ctlIn  = ctlIn + 2'd1;
    reqIn  = ~reqIn;
  endtask

  function automatic int lowExp(int m);
    if (m >= DIS_T + 3) return 2;
    if (m >= RST_T + 3) return 1;
    return 0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(0, "R1");
    repeat (8) tick(0, "R1");

    // long low sweep through both thresholds
    statusIn = 0;
    for (int m = 1; m <= DIS_T + 8; m++) tick(lowExp(m), m < DIS_T ? "R2" : "R3");
    // recovery from disabled
    statusIn = 1;
    for (int m = 1; m <= 8; m++) tick(m >= MINH + 2 ? 0 : 2, "R8");

    // short glitches inside a low stretch must not restart the count
    statusIn = 0;
    for (int m = 1; m <= RST_T + 8; m++) begin
      statusIn = (m == 9 || m == 10 || m == 16) ? 1'b1 : 1'b0;
      tick(lowExp(m), "R5");
    end
    // recovery from reset state
    statusIn = 1;
    for (int m = 1; m <= 8; m++) tick(m >= MINH + 2 ? 0 : 1, "R8");

    // pulse train with lows under the limit stays active
    for (int p = 0; p < 6; p++) begin
      statusIn = 0; repeat (RST_T - MINH - 8) tick(0, "R4");
      statusIn = 1; repeat (MINH + 1) tick(0, "R4");
    end
    repeat (4) tick(0, "R4");

    // link-active flag with the control bit cleared, active and reset
    linkCtrlBit = 0;
    repeat (3) tick(0, "R9");
    statusIn = 0;
    for (int m = 1; m <= RST_T + 5; m++) tick(lowExp(m), "R9");
    statusIn = 1;
    for (int m = 1; m <= 6; m++) tick(m >= MINH + 2 ? 0 : 1, "R9");
    linkCtrlBit = 1;
    repeat (3) tick(0, "R9");

    // power-down forces reset, release returns to active
    powerDown = 1;
    repeat (6) tick(1, "R10");
    powerDown = 0;
    repeat (4) tick(0, "R10");

    // clock gating phase alignment after disable and release (R11)
    statusIn = 0;
    for (int m = 1; m <= DIS_T + 4; m++) tick(lowExp(m), "R11");
    statusIn = 1;
    for (int m = 1; m <= 7; m++) tick(m >= MINH + 2 ? 0 : 2, "R11");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule